// File: doc/BRIEF.md
# Configurable Frame Deserializer

The block turns a serial bit stream, sampled on the receive clock, into parallel words. A one-cycle start strobe opens a frame. From the following clock edge on, one bit is taken per cycle, and bits are gathered into words whose length and bit order are set at run time. After the configured number of words the frame closes, and the block waits for the next start.

Each finished word is shown right-aligned on a 32-bit output, together with a single-cycle valid strobe. A frame-done pulse marks the final word of the frame. A loopback select takes the bit stream from the local transmit data line instead of the receive pin, so the receive path can be tested without external wiring.

Top module: `frame_deser`

## Requirements
- R1: The first data bit is sampled on the clock edge after the one that accepts start. Each word holds len_i+1 bits, with len_i in 1..31. The word is right-aligned on word_o, and every bit above bit len_i reads 0.
- R2: A length code of 0 is handled as 1, so each word has 2 bits.
- R3: A frame carries cnt_i+1 words (cnt_i in 0..15). The block then returns to idle and gives no further valid strobe until the next accepted start. A start in the cycle right after the final bit's edge is accepted.
- R4: With msb_first_i=1, the first received bit of a word goes to bit len_i of word_o and the last received bit goes to bit 0.
- R5: With msb_first_i=0, the first received bit of a word goes to bit 0 and the last received bit goes to bit len_i.
- R6: With loop_en_i=1, bits are taken from loop_bit_i and rx_bit_i is ignored. With loop_en_i=0, bits are taken from rx_bit_i and loop_bit_i is ignored.
- R7: word_valid_o is high for exactly one cycle, directly after the edge that samples a word's last bit. frame_done_o is high only together with the valid strobe of the frame's final word.
- R8: A start strobe that arrives while a frame is active has no effect.
- R9: len_i, cnt_i, msb_first_i and loop_en_i are captured when start is accepted. Changing them during a frame has no effect on that frame.
- R10: While rst_ni is low, word_o is 0, word_valid_o is 0, frame_done_o is 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial data from the receive pin |
| loop_bit_i | input | 1 | Local transmit data line, used for loopback |
| start_i | input | 1 | Transfer start strobe |
| len_i | input | 5 | Word length code (bits per word minus one) |
| cnt_i | input | 4 | Words per frame minus one |
| msb_first_i | input | 1 | Bit order select |
| loop_en_i | input | 1 | Loopback select |
| word_o | output | 32 | Last received word, right-aligned |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| frame_done_o | output | 1 | Strobe for the final word of a frame |

## Verification
The hardest cases to reach from the ports are the ones where the inputs are busy but the block must not react: a second start or a configuration change arriving part-way through a frame. The driver can raise start, or switch every configuration field, during the first word of an active frame. It still predicts the words from the settings captured at the start. It then keeps toggling the data inputs through a long idle stretch, so that any extra word or early frame end shows up in the scoreboard as an unexpected item. Back-to-back frames, and the longest words and frames, also exercise the return to idle on the frame's last bit.

// File: rtl/frame_deser_pkg.sv
package frame_deser_pkg;
  parameter int unsigned LEN_W = 5;
  parameter int unsigned CNT_W = 4;
  localparam int unsigned DATA_W = 1 << LEN_W;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [CNT_W-1:0] cnt;
    logic             msb_first;
    logic             loop_en;
  } rx_cfg_t;

  // length code 0 is forbidden; run it as 2-bit words
  function automatic logic [LEN_W-1:0] fix_len(input logic [LEN_W-1:0] l);
    return (l == '0) ? LEN_W'(1) : l;
  endfunction
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_deser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  rx_cfg_t          cfg_i,
  output rx_cfg_t          cfg_o,
  output logic             busy_o,
  output logic             first_bit_o,
  output logic             last_bit_o,
  output logic             last_word_o,
  output logic [LEN_W-1:0] pos_o
);
  rx_cfg_t          cfg_q;
  logic             busy_q;
  logic [LEN_W-1:0] bit_idx_q;
  logic [CNT_W-1:0] word_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cfg_q      <= '0;
      bit_idx_q  <= '0;
      word_idx_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q     <= 1'b1;
        cfg_q      <= cfg_i;
        cfg_q.len  <= fix_len(cfg_i.len);
        bit_idx_q  <= '0;
        word_idx_q <= '0;
      end
    end else if (bit_idx_q == cfg_q.len) begin
      bit_idx_q <= '0;
      if (word_idx_q == cfg_q.cnt) busy_q <= 1'b0;
      else                         word_idx_q <= word_idx_q + 1'b1;
    end else begin
      bit_idx_q <= bit_idx_q + 1'b1;
    end
  end

  assign cfg_o       = cfg_q;
  assign busy_o      = busy_q;
  assign first_bit_o = (bit_idx_q == '0);
  assign last_bit_o  = busy_q && (bit_idx_q == cfg_q.len);
  assign last_word_o = (word_idx_q == cfg_q.cnt);
  assign pos_o       = cfg_q.msb_first ? (cfg_q.len - bit_idx_q) : bit_idx_q;

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last_bit_o) |=> (busy_q && $stable(cfg_q)));

  assert_cfg_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !(last_bit_o && last_word_o)) |=> $stable(cfg_q));

  assert_len_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cfg_q.len != '0));
endmodule

// File: rtl/word_asm.sv
module word_asm
  import frame_deser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic              last_word_i,
  input  logic [LEN_W-1:0]  pos_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              done_o
);
  logic [DATA_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d        = first_i ? '0 : acc_q;
    acc_d[pos_i] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= sample_i && last_i;
      done_o  <= sample_i && last_i && last_word_i;
      if (sample_i) acc_q <= acc_d;
      if (sample_i && last_i) word_o <= acc_d;
    end
  end

  assert_done_with_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  assert_valid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_word_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_o) && !valid_o |-> $stable(word_o));
endmodule

// File: rtl/frame_deser.sv
module frame_deser
  import frame_deser_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_bit_i,
  input  logic        loop_bit_i,
  input  logic        start_i,
  input  logic [4:0]  len_i,
  input  logic [3:0]  cnt_i,
  input  logic        msb_first_i,
  input  logic        loop_en_i,
  output logic [31:0] word_o,
  output logic        word_valid_o,
  output logic        frame_done_o
);
  rx_cfg_t          cfg_in, cfg;
  logic             busy, first_bit, last_bit, last_word, ser_bit;
  logic [LEN_W-1:0] pos;

  assign cfg_in = '{len: len_i, cnt: cnt_i, msb_first: msb_first_i, loop_en: loop_en_i};

  frame_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cfg_i      (cfg_in),
    .cfg_o      (cfg),
    .busy_o     (busy),
    .first_bit_o(first_bit),
    .last_bit_o (last_bit),
    .last_word_o(last_word),
    .pos_o      (pos)
  );

  assign ser_bit = cfg.loop_en ? loop_bit_i : rx_bit_i;

  word_asm u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (busy),
    .first_i    (first_bit),
    .last_i     (last_bit),
    .last_word_i(last_word),
    .pos_i      (pos),
    .bit_i      (ser_bit),
    .word_o     (word_o),
    .valid_o    (word_valid_o),
    .done_o     (frame_done_o)
  );

  assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> ((word_o >> ({1'b0, cfg.len} + 6'd1)) == '0));

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !$past(busy)) |-> !word_valid_o);
endmodule

// File: tb/frame_deser_test.sv
module frame_deser_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit = 1'b0, loop_bit = 1'b0, start = 1'b0;
  logic [4:0]  len = '0;
  logic [3:0]  cnt = '0;
  logic        msb = 1'b0, lpen = 1'b0;
  logic [31:0] word;
  logic        valid, done;

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R10";
  logic [15:0] lfsr = 16'hACE1;
  logic [32:0] exp_q[$];

  always #4 clk = ~clk;

  frame_deser uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .loop_bit_i(loop_bit),
    .start_i(start), .len_i(len), .cnt_i(cnt), .msb_first_i(msb),
    .loop_en_i(lpen), .word_o(word), .word_valid_o(valid), .frame_done_o(done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // monitor: pops expected items as words appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !valid) check({cur_req, " R7 done without valid"}, 0, 1);
      if (valid) begin
        if (exp_q.size() == 0) check({cur_req, " R3 R8 unexpected word"}, {31'd0, done, word}, 0);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          check({cur_req, " word"}, {31'd0, done, word}, {31'd0, e});
        end
      end
    end
  end

  task automatic run_frame(input logic [4:0] l, input logic [3:0] c, input logic m,
                           input logic lp, input bit mid_start, input bit mid_cfg);
    int nb;
    nb = (l == 0) ? 2 : int'(l) + 1;
    @(negedge clk);
    len = l; cnt = c; msb = m; lpen = lp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_cfg) begin len = ~l; cnt = ~c; msb = ~m; lpen = ~lp; end
    for (int w = 0; w <= int'(c); w++) begin
      logic [31:0] e;
      e = '0;
      for (int i = 0; i < nb; i++) begin
        logic b;
        b = next_bit();
        if (lp) begin loop_bit = b; rx_bit = ~b; end
        else    begin rx_bit = b; loop_bit = ~b; end
        e[m ? (nb - 1 - i) : i] = b;
        start = (mid_start && w == 0 && i == 1);
        if (i == nb - 1) exp_q.push_back({(w == int'(c)), e});
        @(negedge clk);
      end
    end
    start = 1'b0;
  endtask

  task automatic idle_noise(input int n);
    for (int i = 0; i < n; i++) begin
      rx_bit = next_bit(); loop_bit = next_bit();
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R10";
    check("R10 word_o in reset", {32'd0, word}, 0);
    check("R10 valid in reset", {63'd0, valid}, 0);
    check("R10 done in reset", {63'd0, done}, 0);
    rst_n = 1'b1;
    idle_noise(5);

    cur_req = "R5 R1"; run_frame(5'd7, 4'd0, 1'b0, 1'b0, 0, 0); idle_noise(3);
    cur_req = "R4";    run_frame(5'd7, 4'd0, 1'b1, 1'b0, 0, 0); idle_noise(3);
    cur_req = "R1";    run_frame(5'd31, 4'd1, 1'b1, 1'b0, 0, 0); idle_noise(3);
    cur_req = "R1 R5"; run_frame(5'd11, 4'd1, 1'b0, 1'b0, 0, 0); idle_noise(3);
    cur_req = "R2";    run_frame(5'd0, 4'd2, 1'b0, 1'b0, 0, 0); idle_noise(3);
    cur_req = "R2 R4"; run_frame(5'd0, 4'd1, 1'b1, 1'b0, 0, 0); idle_noise(3);
    cur_req = "R6";    run_frame(5'd4, 4'd3, 1'b0, 1'b1, 0, 0); idle_noise(3);
    cur_req = "R6";    run_frame(5'd9, 4'd1, 1'b1, 1'b1, 0, 0); idle_noise(3);
    cur_req = "R8";    run_frame(5'd6, 4'd2, 1'b1, 1'b0, 1, 0); idle_noise(40);
    check("R8 queue drained after ignored start", exp_q.size(), 0);
    cur_req = "R9";    run_frame(5'd5, 4'd1, 1'b0, 1'b0, 0, 1); idle_noise(40);
    check("R9 queue drained after config change", exp_q.size(), 0);
    cur_req = "R3 back-to-back";
    run_frame(5'd3, 4'd1, 1'b0, 1'b0, 0, 0);
    run_frame(5'd3, 4'd0, 1'b1, 1'b0, 0, 0);
    cur_req = "R3";    run_frame(5'd15, 4'd15, 1'b0, 1'b0, 0, 0); idle_noise(40);
    check("R3 no extra words after frame", exp_q.size(), 0);
    check("R7 valid low when idle", {63'd0, valid}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule